// File: doc/BRIEF.md
# Configurable SPI Frame Master

This block is a single-channel SPI master that moves one fixed-size frame per chip-select window. A client places a transmit word on a parallel input and pulses a start strobe. The block then pulls chip select low, clocks out the word MSB first, and samples MISO into a receive word. The block gives the received word back with a one-cycle done pulse. Clock polarity, clock phase, the SPI clock divider, the frame length, the MISO capture delay and the inter-frame gap are configuration inputs. They are sampled when a frame is launched.

Chip select frames the data with one idle SPI clock period before the data bits and one after them. MISO capture can be held back for a programmable number of SPI clocks, so that a slave whose data becomes valid late can still be read. After each frame the block waits one SPI clock plus a number of pulses on a coarse timer tick input before it accepts the next frame. A start that arrives while a frame or a gap is in progress is kept and launched later.

Top module: `spi_frame_master`

## Requirements
- R1: Chip select (active low) stays low for exactly F+2 SPI clock periods. F is the frame-size input, valid from 1 to FRAME_W; 0 or any larger value means FRAME_W. One SPI clock period is 8*(divider+1) core clock cycles.
- R2: While chip select is high, and in the first and last SPI periods of the window, SCLK sits at its idle level. The idle level is low for polarity 0 and high for polarity 1.
- R3: Each frame carries exactly F SCLK pulses, which is 2*F SCLK transitions. They fall in periods 1 to F of the chip-select window.
- R4: MOSI sends transmit bits F-1 down to 0, MSB first, one per data period. With phase 0 the slave samples on the first SCLK edge of each bit. With phase 1 it samples on the second edge.
- R5: MISO is sampled on the same edge as the slave samples MOSI, MSB first. The receive word holds the frame in bits F-1..0. Data period k (k = 1..F) is captured only if k is at least the capture-delay input. Bits that are not captured, and bits at F and above, read 0.
- R6: A capture delay larger than F yields an all-zero receive word.
- R7: done is high for exactly one cycle: the first cycle in which chip select is high again. From that cycle the receive output holds the new word until the next done.
- R8: With a gap setting of 0, busy stays high for exactly one SPI clock period (8*(divider+1) cycles) after chip select rises, then drops.
- R9: With a gap setting N>0, busy stays high for one SPI clock period plus N tick pulses. The tick count may run short by up to one tick period.
- R10: A start seen while busy is held, together with its word, and launched after the gap ends. busy remains high in the meantime. Further starts seen while one is already held are dropped.
- R11: After reset, and whenever no frame is running, chip select is high and MOSI is low. busy is low only when no frame, gap or held start is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_cpol_i | input | 1 | SCLK idle level |
| cfg_cpha_i | input | 1 | 0: sample on first edge of a bit, 1: on second edge |
| cfg_div_i | input | DIV_W | SPI clock divider; SPI period = 8*(value+1) core cycles |
| cfg_frame_bits_i | input | FB_W | Data bits per frame (0 or >FRAME_W means FRAME_W) |
| cfg_in_delay_i | input | DLY_W | First data period whose MISO bit is captured |
| cfg_gap_i | input | GAP_W | Inter-frame gap in tick pulses after one SPI clock |
| tick_i | input | 1 | Coarse timer pulse, one core cycle wide |
| start_i | input | 1 | Frame start request |
| tx_word_i | input | FRAME_W | Word to send, sampled with start |
| rx_word_o | output | FRAME_W | Received word of the last frame |
| done_o | output | 1 | One-cycle frame-complete pulse |
| busy_o | output | 1 | Frame, gap or held start outstanding |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data out |
| cs_n_o | output | 1 | Chip select, active low |
| miso_i | input | 1 | Serial data in |

## Verification
Each of the four polarity/phase combinations is driven against a slave model that changes MISO after every sample edge. A wrong edge choice therefore shows up as shifted receive data, and not only as a wrong SCLK level. Capture delays of 0, 1, F, F+1 and far beyond F distinguish an off-by-one in the capture window from a failure to suppress capture. Frame sizes of 1, 8 and 32, the zero size value, and random sizes show whether the length of the window and the alignment of the received word follow the setting. Gap settings of 0 and of several ticks, together with a start issued mid-frame and a second one after it, separate the one-clock minimum gap, tick counting and the single held request.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE    = 2'd0,
      SEQ_FRAME   = 2'd1,
      SEQ_GAPCLK  = 2'd2,
      SEQ_GAPTICK = 2'd3
   } seq_state_t;

   // core cycles per SPI half period for divider value zero
   localparam int unsigned HALF_PRESCALE = 4;

endpackage

// File: rtl/spi_fm_halfclk.sv
// Half-period strobe of the SPI clock: one pulse every PRE*(div+1) cycles.
module spi_fm_halfclk #(
   parameter int DIV_W = 16,
   parameter int PRE   = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             restart_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             strobe_o
);
   localparam int PRE_LG = (PRE > 1) ? $clog2(PRE) : 1;
   localparam int CNT_W  = DIV_W + PRE_LG + 1;

   logic [CNT_W-1:0] reload_d;
   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] cnt_q;

   generate
      if ((PRE & (PRE - 1)) == 0) begin : g_pow2
         assign reload_d = ((CNT_W'(div_i) + CNT_W'(1)) << $clog2(PRE)) - CNT_W'(1);
      end else begin : g_mult
         assign reload_d = (CNT_W'(div_i) + CNT_W'(1)) * CNT_W'(PRE) - CNT_W'(1);
      end
   endgenerate

   assign strobe_o = (cnt_q == '0) && !restart_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         reload_q <= '0;
         cnt_q    <= '0;
      end else if (restart_i) begin
         reload_q <= reload_d;
         cnt_q    <= reload_d;
      end else if (cnt_q == '0) begin
         cnt_q <= reload_q;
      end else begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

endmodule

// File: rtl/spi_fm_shift.sv
// Transmit and receive shift registers; frames are left-justified on send.
module spi_fm_shift #(
   parameter int W    = 32,
   parameter int FB_W = 6
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            load_i,
   input  logic [W-1:0]    tx_i,
   input  logic [FB_W-1:0] fb_i,
   input  logic            adv_i,
   output logic            msb_o,
   input  logic            smp_i,
   input  logic            bit_i,
   output logic [W-1:0]    rx_o
);
   logic [W-1:0] tx_q;
   logic [W-1:0] rx_q;

   assign msb_o = tx_q[W-1];
   assign rx_o  = rx_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tx_q <= '0;
      end else if (load_i) begin
         tx_q <= tx_i << (W - int'(fb_i));
      end else if (adv_i) begin
         tx_q <= {tx_q[W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rx_q <= '0;
      end else if (load_i) begin
         rx_q <= '0;
      end else if (smp_i) begin
         rx_q <= {rx_q[W-2:0], bit_i};
      end
   end

endmodule

// File: rtl/spi_fm_gap.sv
// Counts coarse tick pulses up to a target.
module spi_fm_gap #(
   parameter int GAP_W = 17
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             tick_i,
   input  logic [GAP_W-1:0] target_i,
   output logic             reached_o
);
   logic [GAP_W-1:0] cnt_q;

   assign reached_o = (cnt_q >= target_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (tick_i && !reached_o) begin
         cnt_q <= cnt_q + GAP_W'(1);
      end
   end

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
   import spi_fm_pkg::*;
#(
   parameter int FRAME_W = 32,
   parameter int DIV_W   = 16,
   parameter int DLY_W   = 8,
   parameter int GAP_W   = 17,
   parameter int FB_W    = $clog2(FRAME_W + 1)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               cfg_cpol_i,
   input  logic               cfg_cpha_i,
   input  logic [DIV_W-1:0]   cfg_div_i,
   input  logic [FB_W-1:0]    cfg_frame_bits_i,
   input  logic [DLY_W-1:0]   cfg_in_delay_i,
   input  logic [GAP_W-1:0]   cfg_gap_i,
   input  logic               tick_i,
   input  logic               start_i,
   input  logic [FRAME_W-1:0] tx_word_i,
   output logic [FRAME_W-1:0] rx_word_o,
   output logic               done_o,
   output logic               busy_o,
   output logic               sclk_o,
   output logic               mosi_o,
   output logic               cs_n_o,
   input  logic               miso_i
);
   localparam int PER_W = $clog2(FRAME_W + 2) + 1;

   generate
      if (FRAME_W < 2) begin : g_bad_frame
         $error("spi_frame_master: FRAME_W must be at least 2");
      end
      if (FB_W < $clog2(FRAME_W + 1)) begin : g_bad_fb
         $error("spi_frame_master: FB_W too narrow for FRAME_W");
      end
      if (DIV_W < 1 || GAP_W < 1 || DLY_W < 1) begin : g_bad_cfg
         $error("spi_frame_master: configuration widths must be positive");
      end
   endgenerate

   seq_state_t         st_q;
   logic [PER_W-1:0]   per_q;
   logic               half_q;
   logic               cpol_q;
   logic               cpha_q;
   logic [FB_W-1:0]    fb_q;
   logic [DLY_W-1:0]   dly_q;
   logic [GAP_W-1:0]   gap_q;
   logic               pend_q;
   logic [FRAME_W-1:0] pend_word_q;
   logic               cs_n_q;
   logic               mosi_q;
   logic               done_q;
   logic [FRAME_W-1:0] rx_word_q;

   logic               launch;
   logic [FRAME_W-1:0] launch_word;
   logic [FB_W-1:0]    fb_eff;
   logic               strobe;
   logic               data_per;
   logic               last_per;
   logic               tx_adv;
   logic               tx_msb;
   logic               rx_smp;
   logic               rx_bit;
   logic [FRAME_W-1:0] rx_sh;
   logic               gap_clr;
   logic               gap_reached;

   // size of zero or beyond the shift register selects the full width
   assign fb_eff = (cfg_frame_bits_i == '0 || int'(cfg_frame_bits_i) > FRAME_W)
                   ? FB_W'(FRAME_W) : cfg_frame_bits_i;

   assign launch      = (st_q == SEQ_IDLE) && (start_i || pend_q);
   assign launch_word = pend_q ? pend_word_q : tx_word_i;

   assign data_per = (per_q != '0) && (per_q <= PER_W'(fb_q));
   assign last_per = (per_q == PER_W'(fb_q) + PER_W'(1));

   assign tx_adv  = (st_q == SEQ_FRAME) && strobe && half_q && (per_q < PER_W'(fb_q));
   assign rx_smp  = (st_q == SEQ_FRAME) && strobe && !half_q && data_per;
   assign rx_bit  = miso_i && (int'(per_q) >= int'(dly_q));
   assign gap_clr = (st_q == SEQ_GAPCLK) && strobe && half_q;

   spi_fm_halfclk #(
      .DIV_W (DIV_W),
      .PRE   (HALF_PRESCALE)
   ) u_halfclk (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (launch),
      .div_i     (cfg_div_i),
      .strobe_o  (strobe)
   );

   spi_fm_shift #(
      .W    (FRAME_W),
      .FB_W (FB_W)
   ) u_shift (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (launch),
      .tx_i   (launch_word),
      .fb_i   (fb_eff),
      .adv_i  (tx_adv),
      .msb_o  (tx_msb),
      .smp_i  (rx_smp),
      .bit_i  (rx_bit),
      .rx_o   (rx_sh)
   );

   spi_fm_gap #(
      .GAP_W (GAP_W)
   ) u_gap (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (gap_clr),
      .tick_i    (tick_i),
      .target_i  (gap_q),
      .reached_o (gap_reached)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q        <= SEQ_IDLE;
         per_q       <= '0;
         half_q      <= 1'b0;
         cpol_q      <= 1'b0;
         cpha_q      <= 1'b0;
         fb_q        <= FB_W'(FRAME_W);
         dly_q       <= '0;
         gap_q       <= '0;
         pend_q      <= 1'b0;
         pend_word_q <= '0;
         cs_n_q      <= 1'b1;
         mosi_q      <= 1'b0;
         done_q      <= 1'b0;
         rx_word_q   <= '0;
      end else begin
         done_q <= 1'b0;
         // hold off one request that arrives outside the idle state
         if (start_i && (st_q != SEQ_IDLE) && !pend_q) begin
            pend_q      <= 1'b1;
            pend_word_q <= tx_word_i;
         end
         unique case (st_q)
            SEQ_IDLE: begin
               cpol_q <= cfg_cpol_i;
               if (launch) begin
                  pend_q <= 1'b0;
                  cpha_q <= cfg_cpha_i;
                  fb_q   <= fb_eff;
                  dly_q  <= cfg_in_delay_i;
                  gap_q  <= cfg_gap_i;
                  per_q  <= '0;
                  half_q <= 1'b0;
                  cs_n_q <= 1'b0;
                  mosi_q <= 1'b0;
                  st_q   <= SEQ_FRAME;
               end
            end
            SEQ_FRAME: begin
               if (strobe) begin
                  if (!half_q) begin
                     half_q <= 1'b1;
                  end else begin
                     half_q <= 1'b0;
                     if (last_per) begin
                        cs_n_q    <= 1'b1;
                        done_q    <= 1'b1;
                        rx_word_q <= rx_sh;
                        mosi_q    <= 1'b0;
                        per_q     <= '0;
                        st_q      <= SEQ_GAPCLK;
                     end else begin
                        per_q  <= per_q + PER_W'(1);
                        mosi_q <= tx_adv ? tx_msb : 1'b0;
                     end
                  end
               end
            end
            SEQ_GAPCLK: begin
               if (strobe) begin
                  if (!half_q) begin
                     half_q <= 1'b1;
                  end else begin
                     half_q <= 1'b0;
                     st_q   <= (gap_q == '0) ? SEQ_IDLE : SEQ_GAPTICK;
                  end
               end
            end
            SEQ_GAPTICK: begin
               if (gap_reached) begin
                  st_q <= SEQ_IDLE;
               end
            end
            default: st_q <= SEQ_IDLE;
         endcase
      end
   end

   // active level only in a data period, during the half chosen by phase
   assign sclk_o    = cpol_q ^ ((st_q == SEQ_FRAME) && data_per && (half_q ^ cpha_q));
   assign mosi_o    = mosi_q;
   assign cs_n_o    = cs_n_q;
   assign done_o    = done_q;
   assign rx_word_o = rx_word_q;
   assign busy_o    = (st_q != SEQ_IDLE) || pend_q;

endmodule

// File: rtl/spi_frame_master_chk.sv
module spi_frame_master_chk #(
   parameter int FB_W = 6
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic            cs_n_o,
   input logic            sclk_o,
   input logic            mosi_o,
   input logic            done_o,
   input logic            busy_o,
   input logic [FB_W-1:0] fb_q
);
   localparam int TOG_W = FB_W + 2;

   logic             sclk_prev_q;
   logic [TOG_W-1:0] tog_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sclk_prev_q <= 1'b0;
         tog_q       <= '0;
      end else begin
         sclk_prev_q <= sclk_o;
         if (cs_n_o) begin
            tog_q <= '0;
         end else if (sclk_o != sclk_prev_q) begin
            tog_q <= tog_q + TOG_W'(1);
         end
      end
   end

   assert_sclk_pulses_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cs_n_o) |-> (tog_q == (TOG_W'(fb_q) << 1)));

   assert_done_at_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cs_n_o) |-> done_o);

   assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   assert_select_needs_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> cs_n_o);

   assert_mosi_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cs_n_o |-> !mosi_o);

   assert_sclk_still_at_select_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(cs_n_o) |-> $stable(sclk_o));

endmodule

bind spi_frame_master spi_frame_master_chk #(.FB_W(FB_W)) u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .cs_n_o (cs_n_o),
   .sclk_o (sclk_o),
   .mosi_o (mosi_o),
   .done_o (done_o),
   .busy_o (busy_o),
   .fb_q   (fb_q)
);

// File: tb/tb_spi_frame_master.sv
module tb_spi_frame_master;
   localparam int W      = 32;
   localparam int TICK_P = 25;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpol = 1'b0, cpha = 1'b0;
   logic [15:0] div = '0;
   logic [5:0]  fbits = '0;
   logic [7:0]  dly = '0;
   logic [16:0] gap = '0;
   logic        tick = 1'b0;
   logic        start = 1'b0;
   logic [W-1:0] txw = '0;
   logic [W-1:0] rxw;
   logic        done, busy, sclk, mosi, cs_n;
   logic        miso = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   int tick_cnt = 0;

   always #2 clk = ~clk;

   spi_frame_master dut (
      .clk_i(clk), .rst_ni(rst_n), .cfg_cpol_i(cpol), .cfg_cpha_i(cpha),
      .cfg_div_i(div), .cfg_frame_bits_i(fbits), .cfg_in_delay_i(dly),
      .cfg_gap_i(gap), .tick_i(tick), .start_i(start), .tx_word_i(txw),
      .rx_word_o(rxw), .done_o(done), .busy_o(busy), .sclk_o(sclk),
      .mosi_o(mosi), .cs_n_o(cs_n), .miso_i(miso));

   always @(negedge clk) begin
      tick_cnt <= (tick_cnt == TICK_P - 1) ? 0 : tick_cnt + 1;
      tick     <= (tick_cnt == TICK_P - 1);
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [W-1:0] frame_mask(input int f);
      return W'((64'd1 << f) - 64'd1);
   endfunction

   function automatic logic [W-1:0] exp_rx(input logic [W-1:0] s, input int f, input int d);
      logic [W-1:0] r = '0;
      for (int i = 0; i < f; i++) begin
         if (i + 1 >= d) r[f-1-i] = s[f-1-i];
      end
      return r;
   endfunction

   // follows one chip-select window as a slave would
   task automatic observe(input logic [W-1:0] slave, input int f, input bit inj,
                          input logic [W-1:0] inj_word,
                          output logic [W-1:0] mbits, output int cs_cyc,
                          output int togs, output bit done_ok, output bit idle_ok,
                          output bit busy_held);
      logic prev;
      int idx;
      mbits = '0; cs_cyc = 0; togs = 0; idle_ok = 1'b1; busy_held = 1'b1;
      while (cs_n) begin
         if (!busy) busy_held = 1'b0;
         @(negedge clk);
      end
      if (sclk != cpol) idle_ok = 1'b0;
      idx = 0;
      miso = slave[f-1];
      prev = sclk;
      cs_cyc = 1;
      forever begin
         @(negedge clk);
         if (cs_n) break;
         cs_cyc++;
         if (inj && cs_cyc == 10) begin start = 1'b1; txw = inj_word; end
         if (inj && cs_cyc == 11) start = 1'b0;
         if (inj && cs_cyc == 20) begin start = 1'b1; txw = ~inj_word; end
         if (inj && cs_cyc == 21) start = 1'b0;
         if (sclk != prev) begin
            bit lead = (prev == cpol);
            togs++;
            if (cpha ? !lead : lead) begin
               mbits = {mbits[W-2:0], mosi};
               idx++;
               miso = (idx < f) ? slave[f-1-idx] : 1'b0;
            end
         end
         prev = sclk;
      end
      done_ok = done;
      if (sclk != cpol) idle_ok = 1'b0;
      miso = 1'b0;
   endtask

   task automatic run(input logic p, input logic h, input int dv, input int fcfg,
                      input int d, input int g, input logic [W-1:0] tx,
                      input logic [W-1:0] slave);
      int f, hp, cs_cyc, togs, bcnt;
      logic [W-1:0] mbits;
      bit done_ok, idle_ok, bh, done_after;
      f  = (fcfg == 0 || fcfg > W) ? W : fcfg;
      hp = 4 * (dv + 1);
      @(negedge clk);
      cpol = p; cpha = h; div = 16'(dv); fbits = 6'(fcfg); dly = 8'(d); gap = 17'(g);
      @(negedge clk);
      start = 1'b1; txw = tx;
      @(negedge clk);
      start = 1'b0;
      observe(slave, f, 1'b0, '0, mbits, cs_cyc, togs, done_ok, idle_ok, bh);
      chk(cs_cyc == (f + 2) * 2 * hp, "R1", "select low cycles", cs_cyc, (f + 2) * 2 * hp);
      chk(idle_ok, "R2", "sclk idle at select edges", sclk, p);
      chk(togs == 2 * f, "R3", "sclk transitions", togs, 2 * f);
      chk(mbits == (tx & frame_mask(f)), "R4", "mosi word", mbits, tx & frame_mask(f));
      chk(rxw == exp_rx(slave, f, d), (d > f) ? "R6" : "R5", "rx word", rxw, exp_rx(slave, f, d));
      chk(done_ok, "R7", "done at release", done_ok, 1);
      bcnt = 0; done_after = 1'b0;
      while (busy) begin
         bcnt++;
         @(negedge clk);
         if (bcnt == 1) done_after = done;
      end
      chk(!done_after, "R7", "done width", done_after, 0);
      if (g == 0)
         chk(bcnt == 2 * hp, "R8", "gap cycles", bcnt, 2 * hp);
      else
         chk(bcnt >= 2 * hp + (g - 1) * TICK_P && bcnt <= 2 * hp + g * TICK_P + 2,
             "R9", "gap cycles", bcnt, 2 * hp + g * TICK_P);
      chk(cs_n && !mosi, "R11", "idle lines", {cs_n, mosi}, 2'b10);
   endtask

   task automatic pend_test();
      logic [W-1:0] a = 32'h0000_00A5, b = 32'h0000_003C, mbits;
      int cs_cyc, togs, falls;
      bit d_ok, i_ok, bh;
      @(negedge clk);
      cpol = 0; cpha = 0; div = 0; fbits = 6'd8; dly = 0; gap = 17'd2;
      @(negedge clk);
      start = 1'b1; txw = a;
      @(negedge clk);
      start = 1'b0;
      observe(32'h0000_0011, 8, 1'b1, b, mbits, cs_cyc, togs, d_ok, i_ok, bh);
      chk(mbits == a, "R10", "first frame word", mbits, a);
      chk(busy, "R10", "busy with held start", busy, 1);
      observe(32'h0000_00C3, 8, 1'b0, '0, mbits, cs_cyc, togs, d_ok, i_ok, bh);
      chk(bh, "R10", "busy across gap", bh, 1);
      chk(mbits == b, "R10", "held frame word", mbits, b);
      chk(rxw == 32'h0000_00C3, "R10", "held frame rx", rxw, 32'h0000_00C3);
      while (busy) @(negedge clk);
      falls = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (!cs_n) falls++;
      end
      chk(falls == 0, "R10", "dropped third start", falls, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (5) @(negedge clk);
      chk(cs_n && !mosi && !busy && !done && rxw == '0 && !sclk, "R11",
          "reset state", {cs_n, mosi, busy, done, sclk}, 5'b10000);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // polarity/phase modes
      run(0, 0, 0, 32, 0, 0, 32'hA5C3_0F96, 32'h3C5A_F00F);
      run(0, 1, 0, 32, 0, 0, 32'h1234_5678, 32'h8765_4321);
      run(1, 0, 1, 32, 0, 0, 32'hDEAD_BEEF, 32'hC0FF_EE11);
      run(1, 1, 1, 32, 0, 0, 32'h0F0F_1E2D, 32'hF1E2_D3C4);
      // capture delay corners
      run(0, 0, 0, 32, 1, 0, 32'h5555_AAAA, 32'hFFFF_FFFF);
      run(0, 1, 0, 32, 32, 0, 32'h0, 32'hFFFF_FFFF);
      run(1, 0, 0, 32, 33, 0, 32'h1, 32'hFFFF_FFFF);
      run(1, 1, 0, 32, 200, 0, 32'h2, 32'hFFFF_FFFF);
      run(0, 0, 0, 32, 7, 1, 32'h8000_0001, 32'hFFFF_FFFF);
      // frame size corners
      run(0, 0, 0, 0, 0, 0, 32'hCAFE_F00D, 32'h1357_9BDF);
      run(1, 0, 0, 1, 0, 0, 32'h1, 32'h1);
      run(0, 1, 2, 8, 3, 3, 32'h0000_00E7, 32'h0000_005B);
      // random mix
      for (int i = 0; i < 12; i++) begin
         int f = $urandom_range(1, 32);
         run(1'($urandom), 1'($urandom), $urandom_range(0, 2), f,
             $urandom_range(0, f + 2), $urandom_range(0, 3), $urandom, $urandom);
      end
      pend_test();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule